// File: doc/BRIEF.md
# Clock Output Enable and Test-State Controller

This controller decides, for every output group of a clock generator, whether the group is driven, parked, or replaced by a divided reference. All of its logic runs on the reference clock. A single shared control pin does two jobs. The first time the pin is sampled low after a power cycle, it means "power good": the controller captures the two strap inputs at that edge. These are the test-select strap and the CPU frequency-select strap. From then on the same pin means "power down" while it is high.

After the capture edge, the controller waits for a start-up window and then releases the groups to run. Test mode can be entered in two ways: through the captured test strap, or through a software entry bit. Once entered, test mode stays on until the next reset, which stands in for a power cycle. While test mode is on, a real-time test pin and a software select bit choose between high impedance and the reference divided by N. The priority between them depends on how test mode was entered.

Power-down parks the differential groups at high impedance and drives the single-ended groups low. It does this combinationally, with no clock edge needed. After the pin drops again, the groups come back only when a re-enable window has elapsed.

Top module: `ckc_ctrl`

## Requirements
- R1: From reset until the first clock edge that samples `pgd_pd_i` low, every group reports mode HIZ (code 2'b00). During that time `freq_100_o` is 1 and `test_sel_o` is 0.
- R2: The first edge that samples `pgd_pd_i` low copies `freq_sel_strap_i` to `freq_100_o` (1 = 100 MHz, 0 = 133 MHz) and copies `test_sel_strap_i` to `test_sel_o`. Later changes on either strap have no effect until reset.
- R3: Counted from the capture edge, all groups stay HIZ for FIRST_DLY edges. After that they report RUN (2'b10), provided test mode is off and no power-down is active.
- R4: Test mode is entered one edge after capture if the test strap was captured as 1. It is also entered at any edge after capture where `reg_test_entry_i` is 1. Once entered, it lasts until `rst_ni` is asserted, even if the entry bit is later cleared.
- R5: In test mode with the test strap captured as 1, all groups report REFN (2'b11) while `test_mode_pin_i` or `reg_test_ref_i` is 1, and HIZ otherwise. Test mode takes priority over power-down.
- R6: In test mode with the test strap captured as 0, `reg_test_ref_i` alone picks REFN (1) or HIZ (0). `test_mode_pin_i` has no effect.
- R7: Outside test mode, `test_mode_pin_i` and `reg_test_ref_i` have no effect on any group.
- R8: After capture and outside test mode, a high `pgd_pd_i` puts groups 0..NUM_DIFF-1 in HIZ and the remaining groups in LOW (2'b01). This takes effect in the same cycle, without waiting for a clock edge.
- R9: After `pgd_pd_i` returns low, the groups keep the power-down modes for REEN_DLY edges, counted from the last edge that sampled the pin high. After that they return to RUN.
- R10: `refn_o` is 0 outside test mode. In test mode it repeats with a period of REF_DIV cycles: it is high for REF_DIV/2 cycles, starting in the cycle after entry.
- R11: Bit g of `grp_oe_o` is 1 exactly when the mode of group g is not HIZ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power cycle) |
| pgd_pd_i | input | 1 | Low: power good (first time); high after capture: power down |
| test_sel_strap_i | input | 1 | Test-select strap |
| freq_sel_strap_i | input | 1 | Frequency-select strap, 1 = 100 MHz |
| test_mode_pin_i | input | 1 | Real-time test-output select pin |
| reg_test_entry_i | input | 1 | Software test-entry bit |
| reg_test_ref_i | input | 1 | Software test-output select bit, 1 = REF/N |
| grp_mode_o | output | 2*(NUM_DIFF+NUM_SE) | Mode per group, group g at bits [2g+1:2g] |
| grp_oe_o | output | NUM_DIFF+NUM_SE | Drive enable per group |
| freq_100_o | output | 1 | Captured frequency select |
| test_sel_o | output | 1 | Captured test select |
| refn_o | output | 1 | Reference divided by REF_DIV |

## Verification
The bench changes both straps right after the capture edge. A design that kept sampling them would then change the frequency or test indication. It raises power-down halfway through a cycle and checks the groups before the next edge, which exposes a power-down that is only registered. It clears the software entry bit after test mode has been entered and toggles the test pin in both strap cases. This shows up a test mode that is not sticky, and a test-pin priority that is applied even when test mode came from software. It also counts the start-up and re-enable windows edge by edge and follows the divided output cycle by cycle, so any off-by-one in the timers or the divider appears as an early or late mode change.

// File: rtl/ckc_pkg.sv
package ckc_pkg;
  typedef enum logic [1:0] {
    GRP_HIZ  = 2'b00,
    GRP_LOW  = 2'b01,
    GRP_RUN  = 2'b10,
    GRP_REFN = 2'b11
  } grp_mode_e;
endpackage

// File: rtl/ckc_strap_latch.sv
module ckc_strap_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pgd_pd_i,
  input  logic test_sel_strap_i,
  input  logic freq_sel_strap_i,
  input  logic reg_test_entry_i,
  output logic latched_o,
  output logic latch_evt_o,
  output logic test_sel_o,
  output logic freq_100_o,
  output logic test_act_o
);
  logic latched_q, tsel_q, fsel_q, test_q;

  assign latch_evt_o = !latched_q && !pgd_pd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latched_q <= 1'b0;
      tsel_q    <= 1'b0;
      fsel_q    <= 1'b1;
      test_q    <= 1'b0;
    end else begin
      if (latch_evt_o) begin
        latched_q <= 1'b1;
        tsel_q    <= test_sel_strap_i;
        fsel_q    <= freq_sel_strap_i;
      end
      // sticky: only reset clears it
      if (latched_q && (tsel_q || reg_test_entry_i)) test_q <= 1'b1;
    end
  end

  assign latched_o  = latched_q;
  assign test_sel_o = tsel_q;
  assign freq_100_o = fsel_q;
  assign test_act_o = test_q;
endmodule

// File: rtl/ckc_hold_timer.sv
module ckc_hold_timer #(
  parameter int DLY = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  localparam int CW = (DLY < 1) ? 1 : $clog2(DLY + 1);
  localparam logic [CW-1:0] DLY_C = CW'(DLY);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= DLY_C;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/ckc_ref_div.sv
module ckc_ref_div #(
  parameter int N = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic refn_o
);
  localparam int CW = (N < 2) ? 1 : $clog2(N);
  localparam logic [CW-1:0] LAST = CW'(N - 1);
  localparam logic [CW-1:0] HALF = CW'(N / 2);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!run_i)       cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign refn_o = run_i && (cnt_q < HALF);
endmodule

// File: rtl/ckc_mode_decode.sv
module ckc_mode_decode
  import ckc_pkg::*;
#(
  parameter int NUM_DIFF = 4,
  parameter int NUM_SE   = 3,
  localparam int NUM_GRP = NUM_DIFF + NUM_SE
) (
  input  logic                   latched_i,
  input  logic                   test_act_i,
  input  logic                   test_sel_i,
  input  logic                   test_pin_i,
  input  logic                   reg_ref_i,
  input  logic                   pd_pin_i,
  input  logic                   start_busy_i,
  input  logic                   reen_busy_i,
  output logic [2*NUM_GRP-1:0]   grp_mode_o
);
  grp_mode_e test_mode;

  // hardware strap lets the pin force REF/N; software entry uses the bit only
  always_comb begin
    if (test_sel_i ? (test_pin_i || reg_ref_i) : reg_ref_i) test_mode = GRP_REFN;
    else                                                     test_mode = GRP_HIZ;
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam grp_mode_e PD_MODE = (g < NUM_DIFF) ? GRP_HIZ : GRP_LOW;
    grp_mode_e m;
    always_comb begin
      if (!latched_i)        m = GRP_HIZ;
      else if (test_act_i)   m = test_mode;
      else if (pd_pin_i)     m = PD_MODE;
      else if (start_busy_i) m = GRP_HIZ;
      else if (reen_busy_i)  m = PD_MODE;
      else                   m = GRP_RUN;
    end
    assign grp_mode_o[2*g +: 2] = m;
  end
endmodule

// File: rtl/ckc_ctrl.sv
module ckc_ctrl
  import ckc_pkg::*;
#(
  parameter int NUM_DIFF  = 4,
  parameter int NUM_SE    = 3,
  parameter int FIRST_DLY = 45000,
  parameter int REEN_DLY  = 6250,
  parameter int REF_DIV   = 6,
  localparam int NUM_GRP  = NUM_DIFF + NUM_SE
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pgd_pd_i,
  input  logic                 test_sel_strap_i,
  input  logic                 freq_sel_strap_i,
  input  logic                 test_mode_pin_i,
  input  logic                 reg_test_entry_i,
  input  logic                 reg_test_ref_i,
  output logic [2*NUM_GRP-1:0] grp_mode_o,
  output logic [NUM_GRP-1:0]   grp_oe_o,
  output logic                 freq_100_o,
  output logic                 test_sel_o,
  output logic                 refn_o
);
  logic latched, latch_evt, test_act, pd_pin, start_busy, reen_busy;

  ckc_strap_latch i_strap (
    .clk_i, .rst_ni, .pgd_pd_i, .test_sel_strap_i, .freq_sel_strap_i,
    .reg_test_entry_i,
    .latched_o(latched), .latch_evt_o(latch_evt), .test_sel_o,
    .freq_100_o, .test_act_o(test_act)
  );

  assign pd_pin = latched && pgd_pd_i;

  ckc_hold_timer #(.DLY(FIRST_DLY)) i_start (
    .clk_i, .rst_ni, .load_i(latch_evt), .busy_o(start_busy)
  );

  ckc_hold_timer #(.DLY(REEN_DLY)) i_reen (
    .clk_i, .rst_ni, .load_i(pd_pin), .busy_o(reen_busy)
  );

  ckc_ref_div #(.N(REF_DIV)) i_div (
    .clk_i, .rst_ni, .run_i(test_act), .refn_o
  );

  ckc_mode_decode #(.NUM_DIFF(NUM_DIFF), .NUM_SE(NUM_SE)) i_dec (
    .latched_i(latched), .test_act_i(test_act), .test_sel_i(test_sel_o),
    .test_pin_i(test_mode_pin_i), .reg_ref_i(reg_test_ref_i),
    .pd_pin_i(pd_pin), .start_busy_i(start_busy), .reen_busy_i(reen_busy),
    .grp_mode_o
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_oe
    assign grp_oe_o[g] = (grp_mode_o[2*g +: 2] != 2'b00);
  end
endmodule

// File: rtl/ckc_ctrl_chk.sv
module ckc_ctrl_chk #(
  parameter int NUM_DIFF = 4,
  parameter int NUM_SE   = 3,
  localparam int NUM_GRP = NUM_DIFF + NUM_SE
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 pgd_pd_i,
  input logic                 latched,
  input logic                 test_act,
  input logic [2*NUM_GRP-1:0] grp_mode_o,
  input logic                 freq_100_o,
  input logic                 test_sel_o,
  input logic                 refn_o
);
  logic [2*NUM_GRP-1:0] pd_pat;
  logic                 any_run;

  always_comb begin
    pd_pat  = '0;
    any_run = 1'b0;
    for (int g = 0; g < NUM_GRP; g++) begin
      pd_pat[2*g +: 2] = (g < NUM_DIFF) ? 2'b00 : 2'b01;
      if (grp_mode_o[2*g +: 2] == 2'b10) any_run = 1'b1;
    end
  end

  assert_hiz_before_latch_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latched |-> grp_mode_o == '0);

  assert_strap_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latched |=> ($stable(freq_100_o) && $stable(test_sel_o)));

  assert_test_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_act |=> test_act);

  assert_no_run_in_test_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_act |-> !any_run);

  assert_pd_park_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latched && pgd_pd_i && !test_act) |-> grp_mode_o == pd_pat);

  assert_refn_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_act |-> !refn_o);
endmodule

bind ckc_ctrl ckc_ctrl_chk #(.NUM_DIFF(NUM_DIFF), .NUM_SE(NUM_SE)) i_ckc_ctrl_chk (
  .clk_i, .rst_ni, .pgd_pd_i, .latched, .test_act,
  .grp_mode_o, .freq_100_o, .test_sel_o, .refn_o
);

// File: tb/test_ckc_ctrl.sv
`timescale 1ns/100ps
module test_ckc_ctrl;
  localparam int ND = 4, NS = 3, NG = ND + NS;
  localparam int FD = 10, RD = 7, DV = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_ni, pin, tsel, fsel, tm, entry, rref;
  logic [2*NG-1:0] grp_mode;
  logic [NG-1:0]   grp_oe;
  logic            freq_100, test_sel, refn;

  ckc_ctrl #(.NUM_DIFF(ND), .NUM_SE(NS), .FIRST_DLY(FD), .REEN_DLY(RD), .REF_DIV(DV)) i_ckc_ctrl (
    .clk_i(clk), .rst_ni, .pgd_pd_i(pin), .test_sel_strap_i(tsel),
    .freq_sel_strap_i(fsel), .test_mode_pin_i(tm), .reg_test_entry_i(entry),
    .reg_test_ref_i(rref), .grp_mode_o(grp_mode), .grp_oe_o(grp_oe),
    .freq_100_o(freq_100), .test_sel_o(test_sel), .refn_o(refn)
  );

  int n_chk = 0, n_fail = 0;
  string phase = "R1";
  bit done = 0;

  // behavioural reference
  bit m_lat, m_tsel, m_fsel, m_test;
  int m_start, m_pd, m_div;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_lat = 0; m_tsel = 0; m_fsel = 1; m_test = 0;
      m_start = 0; m_pd = 0; m_div = 0;
    end else begin
      bit evt, nt;
      evt = !m_lat && !pin;
      nt  = m_test || (m_lat && (m_tsel || entry));
      m_div = m_test ? (m_div + 1) % DV : 0;
      if (evt) m_start = FD; else if (m_start > 0) m_start--;
      if (m_lat && pin) m_pd = RD; else if (m_pd > 0) m_pd--;
      if (evt) begin m_lat = 1; m_tsel = tsel; m_fsel = fsel; end
      m_test = nt;
    end
  end

  function automatic logic [1:0] exp_mode(int g);
    logic [1:0] pdm;
    bit sel;
    pdm = (g < ND) ? 2'b00 : 2'b01;
    sel = m_tsel ? (tm || rref) : rref;
    if (!m_lat) return 2'b00;
    if (m_test) return sel ? 2'b11 : 2'b00;
    if (pin) return pdm;
    if (m_start > 0) return 2'b00;
    if (m_pd > 0) return pdm;
    return 2'b10;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    for (int g = 0; g < NG; g++) begin
      chk(phase, $sformatf("mode[%0d]", g), 32'(grp_mode[2*g +: 2]), 32'(exp_mode(g)));
      chk("R11", $sformatf("oe[%0d]", g), 32'(grp_oe[g]), 32'(exp_mode(g) != 2'b00));
    end
    chk("R2", "freq_100", 32'(freq_100), 32'(m_fsel));
    chk("R2", "test_sel", 32'(test_sel), 32'(m_tsel));
    chk("R10", "refn", 32'(refn), 32'(m_test && (m_div < DV / 2)));
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_ni = 0; pin = 1; tm = 0; entry = 0; rref = 0;
    step(2);
    rst_ni = 1;
  endtask

  initial begin
    rst_ni = 0; pin = 1; tsel = 0; fsel = 1; tm = 0; entry = 0; rref = 0;
    step(3);
    chk("R1", "reset modes", 32'(grp_mode), 0);
    chk("R1", "reset freq", 32'(freq_100), 1);
    rst_ni = 1;
    step(5);
    chk("R1", "pre-capture modes", 32'(grp_mode), 0);

    // normal path, straps 0/0
    phase = "R2"; fsel = 0; tsel = 0; pin = 0;
    step(1);
    fsel = 1; tsel = 1;
    step(2);
    chk("R2", "freq kept 133", 32'(freq_100), 0);
    chk("R2", "tsel kept 0", 32'(test_sel), 0);
    phase = "R3";
    step(2);
    chk("R3", "hiz in startup", 32'(grp_mode[1:0]), 0);
    step(FD);
    chk("R3", "run after startup", 32'(grp_mode[1:0]), 2);
    phase = "R7"; tm = 1; rref = 1;
    step(3);
    chk("R7", "pins ignored", 32'(grp_mode[1:0]), 2);
    tm = 0; rref = 0;
    step(2);
    phase = "R8"; pin = 1;
    #0.5;
    chk("R8", "diff hiz async", 32'(grp_mode[1:0]), 0);
    chk("R8", "se low async", 32'(grp_mode[2*ND +: 2]), 1);
    step(4);
    phase = "R9"; pin = 0;
    step(2);
    chk("R9", "still parked", 32'(grp_mode[2*ND +: 2]), 1);
    step(RD + 1);
    chk("R9", "run again", 32'(grp_mode[2*ND +: 2]), 2);

    // hardware strap test entry
    do_reset();
    tsel = 1; fsel = 1; pin = 0;
    phase = "R4";
    step(3);
    chk("R4", "tsel captured", 32'(test_sel), 1);
    chk("R2", "freq 100", 32'(freq_100), 1);
    phase = "R5"; tm = 1;
    step(3);
    chk("R5", "refn by pin", 32'(grp_mode[1:0]), 3);
    tm = 0;
    step(2);
    chk("R5", "hiz", 32'(grp_mode[1:0]), 0);
    rref = 1;
    step(2);
    chk("R5", "refn by bit", 32'(grp_mode[2*ND +: 2]), 3);
    rref = 0;
    phase = "R10"; tm = 1;
    step(3 * DV);
    phase = "R4"; tsel = 0; pin = 1;
    step(4);
    chk("R5", "test beats pd", 32'(grp_mode[2*ND +: 2]), 3);

    // software test entry
    do_reset();
    tsel = 0; fsel = 0; pin = 0;
    phase = "R3";
    step(FD + 3);
    phase = "R7"; tm = 1;
    step(2);
    chk("R7", "pin ignored", 32'(grp_mode[1:0]), 2);
    tm = 0;
    phase = "R4"; entry = 1;
    step(1);
    entry = 0;
    step(2);
    chk("R4", "sticky test hiz", 32'(grp_mode[1:0]), 0);
    phase = "R6"; tm = 1;
    step(2);
    chk("R6", "pin ignored in test", 32'(grp_mode[1:0]), 0);
    rref = 1;
    step(2);
    chk("R6", "refn by bit", 32'(grp_mode[1:0]), 3);
    phase = "R10";
    step(2 * DV);
    phase = "R6"; pin = 1;
    step(2);
    chk("R6", "pd ignored in test", 32'(grp_mode[1:0]), 3);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule